// File: doc/BRIEF.md
# Programmable Serial Character Transmitter

This block turns bytes written into a single-entry holding register into asynchronous serial frames on one output line. Each accepted byte moves into a separate shift register as soon as the shifter is free. From there it is sent as a low start bit, the data bits least significant first, an optional parity bit and a high stop period. Between frames the line rests high.

All timing comes from a tick input that pulses at sixteen times the bit rate. Every bit therefore spans a fixed number of ticks, and the stop period can be one, one and a half or two bit times. Character length, parity and stop length are taken from format inputs at the moment a byte moves into the shifter. Two flags report whether the holding register can accept another byte and whether the whole transmitter has gone quiet.

Top module: `sertx_top`

## Requirements
- R1: While `rst_ni` is low, `txd_o` is 1, `hold_empty_o` is 1 and `tx_empty_o` is 1. This holds immediately, even in the middle of a frame.
- R2: A frame is one start bit at 0, then the data bits least significant bit first, then the stop period at 1. Each start, data or parity bit lasts exactly 16 ticks. When no frame is being sent, the line is 1.
- R3: `len_sel_i` selects the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Written bits above the selected length are not sent.
- R4: `par_sel_i` selects parity: 01 is even parity, 10 is odd parity, and 00 or 11 means no parity bit is sent. The parity bit comes straight after the last data bit and is computed over the sent data bits only.
- R5: With `stop_long_i` at 0 the stop period lasts 16 ticks. With `stop_long_i` at 1 it lasts 24 ticks for 5-bit characters and 32 ticks for 6 to 8 bit characters.
- R6: `hold_empty_o` goes to 0 in the cycle after a write. It returns to 1 on the same clock edge at which the byte moves into the shifter, which is also the edge at which the start bit begins.
- R7: `tx_empty_o` is 1 only when the holding register is empty and no frame is in progress.
- R8: A byte written while a frame is in progress waits in the holding register. Its start bit begins on the tick that ends the current stop period, with no idle time in between.
- R9: The format inputs are sampled only when a byte moves into the shifter. Changing them during a frame does not alter that frame.
- R10: `txd_o` changes only on a clock edge where the tick is high, or on the edge at which a byte moves into the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Single-cycle pulse at 16 times the bit rate |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Byte to transmit |
| len_sel_i | input | 2 | Character length select |
| par_sel_i | input | 2 | Parity mode select |
| stop_long_i | input | 1 | Selects the long stop period |
| txd_o | output | 1 | Serial output line |
| hold_empty_o | output | 1 | Holding register can accept a byte |
| tx_empty_o | output | 1 | Holding register and shifter both idle |

## Verification
The bench records the line level in front of every tick. It then compares whole frames, sixteenth by sixteenth, against waveforms it builds from the format settings. A bad bit counter or shift position shows up within one bit time as a wrong level on the line. A bad stop counter shows up as a start bit that arrives early or late by a whole number of ticks. A wrong hold-to-shift handover shows up on the two flags one cycle after the write, or as an idle gap between frames that were written back to back.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PARITY,
    TX_STOP
  } tx_state_e;

  typedef enum logic [1:0] {
    PAR_NONE     = 2'b00,
    PAR_EVEN     = 2'b01,
    PAR_ODD      = 2'b10,
    PAR_NONE_ALT = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic [1:0] len_code;
    par_mode_e  par_mode;
    logic       stop_long;
  } tx_fmt_t;

endpackage

// File: rtl/sertx_hold.sv
`timescale 1ns/1ps
module sertx_hold #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          take_i,
  output logic          full_o,
  output logic [DW-1:0] data_o
);

  logic          full_q;
  logic [DW-1:0] data_q;

  // write wins over take: shifter grabs old data on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_en_i) begin
        full_q <= 1'b1;
        data_q <= wr_data_i;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

endmodule

// File: rtl/sertx_fmt.sv
`timescale 1ns/1ps
module sertx_fmt
  import sertx_pkg::*;
#(
  parameter int DW = 8,
  parameter int OS = 16,
  parameter int BW = $clog2(DW),
  parameter int CW = $clog2(2 * OS)
) (
  input  tx_fmt_t       fmt_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic [BW-1:0] last_bit_o,
  output logic          par_en_o,
  output logic          par_bit_o,
  output logic [CW-1:0] stop_last_o
);

  localparam int MIN_BITS = DW - 3;
  localparam logic [CW-1:0] STOP_ONE   = CW'(OS - 1);
  localparam logic [CW-1:0] STOP_HALF  = CW'(OS + OS / 2 - 1);
  localparam logic [CW-1:0] STOP_TWO   = CW'(2 * OS - 1);

  logic [DW-1:0] masked;

  always_comb begin
    last_bit_o = BW'(MIN_BITS - 1) + BW'(fmt_i.len_code);
    for (int i = 0; i < DW; i++) begin
      masked[i] = data_i[i] & (BW'(i) <= last_bit_o);
    end
  end

  assign data_o    = masked;
  assign par_en_o  = (fmt_i.par_mode == PAR_EVEN) || (fmt_i.par_mode == PAR_ODD);
  assign par_bit_o = (^masked) ^ (fmt_i.par_mode == PAR_ODD);

  always_comb begin
    if (!fmt_i.stop_long)           stop_last_o = STOP_ONE;
    else if (fmt_i.len_code == 2'd0) stop_last_o = STOP_HALF;
    else                            stop_last_o = STOP_TWO;
  end

endmodule

// File: rtl/sertx_shift.sv
`timescale 1ns/1ps
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DW = 8,
  parameter int OS = 16,
  parameter int BW = $clog2(DW),
  parameter int CW = $clog2(2 * OS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic [BW-1:0] last_bit_i,
  input  logic          par_en_i,
  input  logic          par_bit_i,
  input  logic [CW-1:0] stop_last_i,
  output logic          txd_o,
  output logic          idle_o,
  output logic          stop_done_o
);

  localparam logic [CW-1:0] BIT_LAST = CW'(OS - 1);

  tx_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [BW-1:0] last_bit_q;
  logic          par_en_q, par_bit_q;
  logic [CW-1:0] stop_last_q;
  logic          txd_q, line_d;
  logic [CW-1:0] seg_last;

  assign seg_last = (state_q == TX_STOP) ? stop_last_q : BIT_LAST;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    if (load_i) begin
      state_d = TX_START;
      cnt_d   = '0;
      bit_d   = '0;
      sh_d    = load_data_i;
    end else if (tick_i && (state_q != TX_IDLE)) begin
      if (cnt_q == seg_last) begin
        cnt_d = '0;
        unique case (state_q)
          TX_START: begin
            state_d = TX_DATA;
            bit_d   = '0;
          end
          TX_DATA: begin
            sh_d = sh_q >> 1;
            if (bit_q == last_bit_q) state_d = par_en_q ? TX_PARITY : TX_STOP;
            else                     bit_d   = bit_q + 1'b1;
          end
          TX_PARITY: state_d = TX_STOP;
          TX_STOP:   state_d = TX_IDLE;
          default:   state_d = TX_IDLE;
        endcase
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (state_d)
      TX_START:  line_d = 1'b0;
      TX_DATA:   line_d = sh_d[0];
      TX_PARITY: line_d = par_bit_q;
      default:   line_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      txd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      txd_q   <= line_d;
    end
  end

  // frame format captured once per character
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_bit_q  <= '0;
      par_en_q    <= 1'b0;
      par_bit_q   <= 1'b0;
      stop_last_q <= BIT_LAST;
    end else if (load_i) begin
      last_bit_q  <= last_bit_i;
      par_en_q    <= par_en_i;
      par_bit_q   <= par_bit_i;
      stop_last_q <= stop_last_i;
    end
  end

  assign txd_o       = txd_q;
  assign idle_o      = (state_q == TX_IDLE);
  assign stop_done_o = (state_q == TX_STOP) && tick_i && (cnt_q == stop_last_q);

endmodule

// File: rtl/sertx_top.sv
`timescale 1ns/1ps
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        len_sel_i,
  input  logic [1:0]        par_sel_i,
  input  logic              stop_long_i,
  output logic              txd_o,
  output logic              hold_empty_o,
  output logic              tx_empty_o
);

  localparam int BW = $clog2(DATA_W);
  localparam int CW = $clog2(2 * OVERSAMPLE);

  tx_fmt_t           fmt;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic [DATA_W-1:0] fmt_data;
  logic [BW-1:0]     last_bit;
  logic              par_en, par_bit;
  logic [CW-1:0]     stop_last;
  logic              sh_idle, sh_stop_done;
  logic              load_w;

  assign fmt.len_code  = len_sel_i;
  assign fmt.par_mode  = par_mode_e'(par_sel_i);
  assign fmt.stop_long = stop_long_i;

  // handover on idle, or on the tick that closes the stop period
  assign load_w = hold_full && (sh_idle || sh_stop_done);

  sertx_hold #(
    .DW(DATA_W)
  ) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .take_i   (load_w),
    .full_o   (hold_full),
    .data_o   (hold_data)
  );

  sertx_fmt #(
    .DW(DATA_W),
    .OS(OVERSAMPLE),
    .BW(BW),
    .CW(CW)
  ) u_fmt (
    .fmt_i      (fmt),
    .data_i     (hold_data),
    .data_o     (fmt_data),
    .last_bit_o (last_bit),
    .par_en_o   (par_en),
    .par_bit_o  (par_bit),
    .stop_last_o(stop_last)
  );

  sertx_shift #(
    .DW(DATA_W),
    .OS(OVERSAMPLE),
    .BW(BW),
    .CW(CW)
  ) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick16_i),
    .load_i     (load_w),
    .load_data_i(fmt_data),
    .last_bit_i (last_bit),
    .par_en_i   (par_en),
    .par_bit_i  (par_bit),
    .stop_last_i(stop_last),
    .txd_o      (txd_o),
    .idle_o     (sh_idle),
    .stop_done_o(sh_stop_done)
  );

  assign hold_empty_o = !hold_full;
  assign tx_empty_o   = !hold_full && sh_idle;

endmodule

// File: rtl/sertx_checker.sv
`timescale 1ns/1ps
module sertx_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic tick16_i,
  input logic wr_en_i,
  input logic load_i,
  input logic txd_o,
  input logic hold_empty_o,
  input logic tx_empty_o
);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> txd_o); // R2

  AST_EMPTY_NEEDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> hold_empty_o); // R7

  AST_WRITE_FILLS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !hold_empty_o); // R6

  AST_HOLD_FREE_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_empty_o) |-> ($past(load_i) && !txd_o)); // R6

  AST_LOAD_STARTS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!txd_o && !tx_empty_o)); // R8

  AST_LINE_MOVES_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txd_o) |-> ($past(tick16_i) || $past(load_i))); // R10

endmodule

bind sertx_top sertx_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick16_i    (tick16_i),
  .wr_en_i     (wr_en_i),
  .load_i      (load_w),
  .txd_o       (txd_o),
  .hold_empty_o(hold_empty_o),
  .tx_empty_o  (tx_empty_o)
);

// File: tb/sertx_top_tb_top.sv
`timescale 1ns/1ps
module sertx_top_tb_top;

  localparam int HMAX = 16384;
  localparam int EMAX = 2048;

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] par;
    logic       stop_long;
    logic [7:0] data;
    logic [5:0] stop_ticks;
  } vec_t;

  // stimulus and expected stop length in ticks
  localparam vec_t VECS [9] = '{
    '{2'd3, 2'd0, 1'b0, 8'hA5, 6'd16},
    '{2'd3, 2'd1, 1'b0, 8'h37, 6'd16},
    '{2'd3, 2'd2, 1'b1, 8'h37, 6'd32},
    '{2'd0, 2'd0, 1'b1, 8'hFF, 6'd24},
    '{2'd0, 2'd2, 1'b1, 8'h0A, 6'd24},
    '{2'd1, 2'd1, 1'b0, 8'h2C, 6'd16},
    '{2'd2, 2'd2, 1'b1, 8'h55, 6'd32},
    '{2'd2, 2'd3, 1'b0, 8'h00, 6'd16},
    '{2'd1, 2'd0, 1'b1, 8'h3F, 6'd32}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] len_sel = '0;
  logic [1:0] par_sel = '0;
  logic       stop_long = 1'b0;
  logic       txd, hold_empty, tx_empty;
  logic [1:0] tdiv = '0;
  logic       tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic hist [HMAX];
  int   nh = 0;
  logic expq [EMAX];
  int   exp_n = 0;

  always #4 clk = ~clk;

  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);

  // line level just before each tick edge
  always @(negedge clk) begin
    if (tick && nh < HMAX) begin
      hist[nh] = txd;
      nh++;
    end
  end

  sertx_top dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick16_i    (tick),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .len_sel_i   (len_sel),
    .par_sel_i   (par_sel),
    .stop_long_i (stop_long),
    .txd_o       (txd),
    .hold_empty_o(hold_empty),
    .tx_empty_o  (tx_empty)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic wait_ticks(input int n);
    int c = 0;
    while (c < n) begin
      @(negedge clk);
      if (tick) c++;
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic push(input logic v, input int n);
    for (int k = 0; k < n; k++) begin
      if (exp_n < EMAX) expq[exp_n] = v;
      exp_n++;
    end
  endtask

  task automatic add_frame(input logic [1:0] len, input logic [1:0] par,
                           input logic [7:0] d, input int stop_ticks);
    int   nb;
    logic p;
    nb = 5 + int'(len);
    p  = 1'b0;
    push(1'b0, 16);
    for (int i = 0; i < nb; i++) begin
      push(d[i], 16);
      p = p ^ d[i];
    end
    if (par == 2'd1) push(p, 16);
    if (par == 2'd2) push(~p, 16);
    push(1'b1, stop_ticks);
  endtask

  task automatic compare_stream(input int mark, input string req);
    int f;
    int bad;
    int first_bad;
    while (!tx_empty) @(negedge clk);
    wait_ticks(2);
    f = -1;
    for (int i = mark; i < nh; i++) begin
      if (hist[i] == 1'b0) begin
        f = i;
        break;
      end
    end
    bad = 0;
    first_bad = -1;
    if (f < 0) begin
      bad = 1;
    end else begin
      for (int t = 0; t <= exp_n; t++) begin
        if ((t < exp_n ? expq[t] : 1'b1) !== hist[f + t]) begin
          if (first_bad < 0) first_bad = t;
          bad++;
        end
      end
    end
    check(bad == 0, req, "line waveform first bad sixteenth", first_bad, -1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int mark;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(txd === 1'b1, "R1", "txd in reset", txd, 1);
    check(hold_empty === 1'b1, "R1", "hold_empty in reset", hold_empty, 1);
    check(tx_empty === 1'b1, "R1", "tx_empty in reset", tx_empty, 1);
    @(negedge clk);
    rst_n = 1'b1;
    wait_ticks(3);

    // table walk: single characters, all lengths and modes
    for (int v = 0; v < 9; v++) begin
      len_sel   = VECS[v].len;
      par_sel   = VECS[v].par;
      stop_long = VECS[v].stop_long;
      mark  = nh;
      exp_n = 0;
      add_frame(VECS[v].len, VECS[v].par, VECS[v].data, int'(VECS[v].stop_ticks));
      write_byte(VECS[v].data);
      check(hold_empty === 1'b0, "R6", "hold_empty after write", hold_empty, 0);
      @(negedge clk);
      check(hold_empty === 1'b1, "R6", "hold_empty after transfer", hold_empty, 1);
      check(tx_empty === 1'b0, "R7", "tx_empty during frame", tx_empty, 0);
      check(txd === 1'b0, "R2", "start bit at transfer", txd, 0);
      compare_stream(mark, "R2 R3 R4 R5 R10");
      check(tx_empty === 1'b1, "R7", "tx_empty after frame", tx_empty, 1);
    end

    // back-to-back with 1.5 stop periods
    len_sel = 2'd0; par_sel = 2'd2; stop_long = 1'b1;
    mark = nh; exp_n = 0;
    add_frame(2'd0, 2'd2, 8'h13, 24);
    add_frame(2'd0, 2'd2, 8'h0C, 24);
    write_byte(8'h13);
    @(negedge clk);
    write_byte(8'h0C);
    check(hold_empty === 1'b0, "R6", "second byte held", hold_empty, 0);
    wait_ticks(30);
    check(tx_empty === 1'b0 && hold_empty === 1'b0, "R7", "busy with held byte",
          tx_empty, 0);
    compare_stream(mark, "R8 R5");

    // format change during first frame applies only to the held byte
    len_sel = 2'd3; par_sel = 2'd0; stop_long = 1'b0;
    mark = nh; exp_n = 0;
    add_frame(2'd3, 2'd0, 8'hC3, 16);
    add_frame(2'd1, 2'd1, 8'h5A, 32);
    write_byte(8'hC3);
    @(negedge clk);
    write_byte(8'h5A);
    wait_ticks(20);
    len_sel = 2'd1; par_sel = 2'd1; stop_long = 1'b1;
    compare_stream(mark, "R9 R8");

    // reset in mid-frame
    len_sel = 2'd3; par_sel = 2'd0; stop_long = 1'b0;
    write_byte(8'h00);
    wait_ticks(40);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(txd === 1'b1, "R1", "txd after mid-frame reset", txd, 1);
    check(hold_empty === 1'b1 && tx_empty === 1'b1, "R1", "flags after mid-frame reset",
          tx_empty, 1);
    @(negedge clk);
    rst_n = 1'b1;
    wait_ticks(3);

    // recovery frame
    mark = nh; exp_n = 0;
    add_frame(2'd2, 2'd1, 8'h6E, 16);
    len_sel = 2'd2; par_sel = 2'd1; stop_long = 1'b0;
    write_byte(8'h6E);
    compare_stream(mark, "R2 R4");

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule